// File: doc/BRIEF.md
# Core Status and Control Register

This block holds the eight-bit status and control word of a small microcontroller core. It is memory-mapped at one address of the core's I/O space. It records the core's run state, a software suspend request, whether interrupts are enabled, whether an interrupt is waiting, and the cause of the last reset: power-on, watchdog, or a reset seen on the upstream USB port. The core reads it back in its reset handler to tell the causes apart.

Three kinds of event reach the register. The first is the reset strobes. The second is the instruction events: halt, enable-interrupt, disable-interrupt and return-from-interrupt. The third is the condition inputs from the interrupt and bus logic. Each reset type preserves a different part of the word. Halt wipes the whole word. Software cannot set the interrupt-enable bit. A suspend request is refused while the bus is busy. The run, suspend and interrupt-enable bits are also brought out as plain outputs for the core's sequencer.

Top module: `core_stat_ctl`

## Requirements
- R1: With `rst` high at a clock edge, the word becomes 0x11 after that edge: run (bit 0) is 1, the power-on flag (bit 4) is 1, and all other bits are 0.
- R2: A `wdog_rst_ev` pulse without `rst` gives the pattern 01XX0001 after the edge. Bits 5 and 4 keep their values, or bit 5 becomes 1 if `busrst_ev` is also high. The watchdog pulse wins over a halt in the same cycle.
- R3: A `halt_ev` pulse, with neither reset present, clears all eight bits to 0, so `run_o` goes low.
- R4: Software writes to bit 2 have no effect. `ei_ev` or `reti_ev` set bit 2. `di_ev` clears it, and wins when it arrives together with either of the other two.
- R5: A write to the register sets suspend (bit 3) to the written value. A write of 1 is ignored while `bus_act` is high in that cycle.
- R6: While suspend is 1, a high `wake` or `bus_act` clears it on the next edge.
- R7: A `busrst_ev` pulse sets bit 5. If a software write clears bit 5 in the same cycle, the set still wins.
- R8: Writing 0 to bit 6, 5 or 4 clears that bit. Writing 1 leaves it unchanged.
- R9: Bit 7 becomes 1 when `irq_req` is high. It stays 1 until the interrupt is taken, which happens in a cycle where bit 7, bit 2 and `irq_src_en` are all 1. It is 0 after that edge.
- R10: Bits 1 and 0 hold the last value written to them.
- R11: Writes take effect only when `bus_addr` equals `REG_ADDR`. `rd_data` shows the word at that address and reads 0 at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| bus_addr | input | ADDR_W | I/O address of the current access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, 0 when the address does not match |
| halt_ev | input | 1 | Halt instruction executed |
| ei_ev | input | 1 | Enable-interrupt instruction executed |
| di_ev | input | 1 | Disable-interrupt instruction executed |
| reti_ev | input | 1 | Return-from-interrupt executed |
| wdog_rst_ev | input | 1 | Watchdog reset strobe |
| busrst_ev | input | 1 | Upstream bus reset detected |
| irq_req | input | 1 | Some interrupt source is active |
| irq_src_en | input | 1 | The active source is individually enabled |
| bus_act | input | 1 | Bus activity present |
| wake | input | 1 | Enabled interrupt pending, wakes from suspend |
| run_o | output | 1 | Run bit |
| susp_o | output | 1 | Suspend bit |
| ie_o | output | 1 | Interrupt-enable sense bit |

## Verification
The bench builds the block with its default eight-bit address and register address 0xFF. With that configuration, every one of the 256 write values can be swept from a fresh power-on state, once with the bus idle and once with it busy. Expected words are formed with a mask over the written value. All four combinations of the power-on and bus-reset flags are walked through a watchdog reset. Simultaneous events are driven on purpose: set against clear, disable against enable, and watchdog against halt.

// File: rtl/stat_ctl_pkg.sv
package stat_ctl_pkg;

    localparam int STAT_W = 8;

    typedef struct packed {
        logic irq_pend;
        logic wdog_flag;
        logic busrst_flag;
        logic por_flag;
        logic susp;
        logic ie;
        logic rsvd;
        logic run;
    } stat_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_POR  = 2'd1,
        EV_WDOG = 2'd2,
        EV_HALT = 2'd3
    } wipe_ev_e;

    localparam int NCAUSE = 3;

    // cause flags ordered {wdog, busrst, por}
    localparam logic [NCAUSE-1:0] CAUSE_POR_INIT = 3'b001;
    localparam logic [NCAUSE-1:0] CAUSE_WDOG_SET = 3'b100;

    function automatic wipe_ev_e pick_wipe(input logic por, input logic wdog,
                                           input logic halt);
        if (por)       return EV_POR;
        else if (wdog) return EV_WDOG;
        else if (halt) return EV_HALT;
        else           return EV_NONE;
    endfunction

endpackage

// File: rtl/cause_flags.sv
module cause_flags
    import stat_ctl_pkg::*;
#(
    parameter int N = NCAUSE,
    parameter logic [N-1:0] POR_INIT = CAUSE_POR_INIT,
    parameter logic [N-1:0] WDOG_SET = CAUSE_WDOG_SET
) (
    input  logic         clk,
    input  wipe_ev_e     ev,
    input  logic [N-1:0] set_stb,
    input  logic [N-1:0] clr_wr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            unique case (ev)
                EV_POR:  flags[i] <= POR_INIT[i];
                EV_WDOG: flags[i] <= WDOG_SET[i] | flags[i] | set_stb[i];
                EV_HALT: flags[i] <= 1'b0;
                default: begin
                    if (set_stb[i])     flags[i] <= 1'b1;
                    else if (clr_wr[i]) flags[i] <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ie_susp_ctl.sv
module ie_susp_ctl
    import stat_ctl_pkg::*;
(
    input  logic     clk,
    input  wipe_ev_e ev,
    input  logic     ei_ev,
    input  logic     di_ev,
    input  logic     reti_ev,
    input  logic     wr,
    input  logic     wd_susp,
    input  logic     bus_act,
    input  logic     wake,
    output logic     ie,
    output logic     susp
);
    always_ff @(posedge clk) begin
        if (ev != EV_NONE) begin
            ie   <= 1'b0;
            susp <= 1'b0;
        end else begin
            if (di_ev)                  ie <= 1'b0;
            else if (ei_ev || reti_ev)  ie <= 1'b1;

            if (susp && (wake || bus_act)) susp <= 1'b0;
            else if (wr)                   susp <= wd_susp && !bus_act;
        end
    end
endmodule

// File: rtl/irq_run_ctl.sv
module irq_run_ctl
    import stat_ctl_pkg::*;
(
    input  logic     clk,
    input  wipe_ev_e ev,
    input  logic     irq_req,
    input  logic     irq_src_en,
    input  logic     ie,
    input  logic     wr,
    input  logic     wd_rsvd,
    input  logic     wd_run,
    output logic     irq_pend,
    output logic     rsvd,
    output logic     run
);
    logic take;
    assign take = irq_pend && irq_src_en && ie;

    always_ff @(posedge clk) begin
        unique case (ev)
            EV_POR, EV_WDOG: begin
                irq_pend <= 1'b0;
                rsvd     <= 1'b0;
                run      <= 1'b1;
            end
            EV_HALT: begin
                irq_pend <= 1'b0;
                rsvd     <= 1'b0;
                run      <= 1'b0;
            end
            default: begin
                if (take)         irq_pend <= 1'b0;
                else if (irq_req) irq_pend <= 1'b1;
                if (wr) begin
                    rsvd <= wd_rsvd;
                    run  <= wd_run;
                end
            end
        endcase
    end
endmodule

// File: rtl/core_stat_ctl.sv
module core_stat_ctl
    import stat_ctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              halt_ev,
    input  logic              ei_ev,
    input  logic              di_ev,
    input  logic              reti_ev,
    input  logic              wdog_rst_ev,
    input  logic              busrst_ev,
    input  logic              irq_req,
    input  logic              irq_src_en,
    input  logic              bus_act,
    input  logic              wake,
    output logic              run_o,
    output logic              susp_o,
    output logic              ie_o
);
    stat_t    stat_q;
    stat_t    wd;
    wipe_ev_e ev;
    logic     sel;
    logic     wr_hit;
    logic [NCAUSE-1:0] cause_q;
    logic unused_wd;

    assign wd      = stat_t'(wr_data);
    assign sel     = (bus_addr == REG_ADDR);
    assign wr_hit  = wr_en && sel;
    assign ev      = pick_wipe(rst, wdog_rst_ev, halt_ev);
    assign unused_wd = wd.irq_pend ^ wd.ie;

    cause_flags u_cause (
        .clk     (clk),
        .ev      (ev),
        .set_stb ({1'b0, busrst_ev, 1'b0}),
        .clr_wr  ({wr_hit && !wd.wdog_flag, wr_hit && !wd.busrst_flag,
                   wr_hit && !wd.por_flag}),
        .flags   (cause_q)
    );

    ie_susp_ctl u_iesusp (
        .clk     (clk),
        .ev      (ev),
        .ei_ev   (ei_ev),
        .di_ev   (di_ev),
        .reti_ev (reti_ev),
        .wr      (wr_hit),
        .wd_susp (wd.susp),
        .bus_act (bus_act),
        .wake    (wake),
        .ie      (stat_q.ie),
        .susp    (stat_q.susp)
    );

    irq_run_ctl u_irqrun (
        .clk        (clk),
        .ev         (ev),
        .irq_req    (irq_req),
        .irq_src_en (irq_src_en),
        .ie         (stat_q.ie),
        .wr         (wr_hit),
        .wd_rsvd    (wd.rsvd),
        .wd_run     (wd.run),
        .irq_pend   (stat_q.irq_pend),
        .rsvd       (stat_q.rsvd),
        .run        (stat_q.run)
    );

    assign stat_q.wdog_flag   = cause_q[2];
    assign stat_q.busrst_flag = cause_q[1];
    assign stat_q.por_flag    = cause_q[0];

    assign rd_data = sel ? stat_q : 8'h00;
    assign run_o   = stat_q.run;
    assign susp_o  = stat_q.susp;
    assign ie_o    = stat_q.ie;
endmodule

// File: rtl/stat_ctl_chk.sv
module stat_ctl_chk
    import stat_ctl_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wr_hit,
    input logic  halt_ev,
    input logic  ei_ev,
    input logic  di_ev,
    input logic  reti_ev,
    input logic  wdog_rst_ev,
    input logic  busrst_ev,
    input logic  bus_act,
    input stat_t stat_q
);
    // R1
    por_value_chk: assert property (@(posedge clk)
        rst |=> (stat_q == 8'h11));

    // R2
    wdog_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_ev |=> (stat_q[7:6] == 2'b01 && stat_q[3:0] == 4'b0001
                         && stat_q.por_flag == $past(stat_q.por_flag)));

    // R3
    halt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_ev && !wdog_rst_ev) |=> (stat_q == 8'h00));

    // R4
    ie_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !ei_ev && !di_ev && !reti_ev && !wdog_rst_ev && !halt_ev)
        |=> $stable(stat_q.ie));

    // R5
    susp_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_q.susp && bus_act) |=> !stat_q.susp);

    // R7
    busrst_set_chk: assert property (@(posedge clk) disable iff (rst)
        (busrst_ev && !halt_ev) |=> stat_q.busrst_flag);
endmodule

bind core_stat_ctl stat_ctl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_hit      (wr_hit),
    .halt_ev     (halt_ev),
    .ei_ev       (ei_ev),
    .di_ev       (di_ev),
    .reti_ev     (reti_ev),
    .wdog_rst_ev (wdog_rst_ev),
    .busrst_ev   (busrst_ev),
    .bus_act     (bus_act),
    .stat_q      (stat_q)
);

// File: tb/core_stat_ctl_tb_top.sv
`timescale 1ns/1ps
module core_stat_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst, wr_en, halt_ev, ei_ev, di_ev, reti_ev, wdog_rst_ev;
    logic       busrst_ev, irq_req, irq_src_en, bus_act, wake;
    logic [7:0] bus_addr, wr_data, rd_data;
    logic       run_o, susp_o, ie_o;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    core_stat_ctl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .halt_ev(halt_ev),
        .ei_ev(ei_ev), .di_ev(di_ev), .reti_ev(reti_ev),
        .wdog_rst_ev(wdog_rst_ev), .busrst_ev(busrst_ev), .irq_req(irq_req),
        .irq_src_en(irq_src_en), .bus_act(bus_act), .wake(wake),
        .run_o(run_o), .susp_o(susp_o), .ie_o(ie_o)
    );

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        rst = 0; wr_en = 0; halt_ev = 0; ei_ev = 0; di_ev = 0; reti_ev = 0;
        wdog_rst_ev = 0; busrst_ev = 0; irq_req = 0; irq_src_en = 0;
        bus_act = 0; wake = 0; bus_addr = 8'hFF; wr_data = 8'h00;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic por();
        rst = 1'b1;
        tick();
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
    endtask

    initial begin
        idle();
        @(negedge clk);
        por();
        // R1
        check("R1 word", rd_data, 8'h11);
        check("R1 outs", {5'b0, run_o, susp_o, ie_o}, 8'b100);

        // R8 R10 R5 R4: sweep every write value, bus idle then busy
        for (int b = 0; b < 2; b++) begin
            for (int v = 0; v < 256; v++) begin
                por();
                bus_act = b[0];
                wr(v[7:0]);
                check(b ? "R5 R8 R10 busy sweep" : "R4 R8 R10 idle sweep",
                      rd_data, v[7:0] & (b ? 8'h13 : 8'h1B));
            end
        end

        // R2: watchdog keeps power-on and bus-reset flags
        for (int v = 0; v < 4; v++) begin
            por();
            wr(8'h61 | (v[0] ? 8'h10 : 8'h00));
            if (v[1]) begin busrst_ev = 1; tick(); end
            ei_ev = 1; tick();
            wdog_rst_ev = 1; tick();
            check("R2 pattern", rd_data, 8'h41 | (8'(v) << 4));
        end
        // R2 watchdog beats halt
        halt_ev = 1; wdog_rst_ev = 1; tick();
        check("R2 over halt", rd_data, 8'h71);

        // R3
        ei_ev = 1; tick();
        halt_ev = 1; tick();
        check("R3 halt", rd_data, 8'h00);
        check("R3 run_o", {7'b0, run_o}, 8'h00);

        // R4 enable/disable events
        por();
        reti_ev = 1; tick();
        check("R4 reti", {7'b0, ie_o}, 8'h01);
        di_ev = 1; ei_ev = 1; tick();
        check("R4 di wins", {7'b0, ie_o}, 8'h00);
        ei_ev = 1; tick();
        wr(8'h01);
        check("R4 write 0 ignored", {7'b0, ie_o}, 8'h01);

        // R6 exit on wake, then on bus activity
        por();
        wr(8'h09);
        check("R6 entered", {7'b0, susp_o}, 8'h01);
        wake = 1; tick();
        check("R6 wake exit", {7'b0, susp_o}, 8'h00);
        wr(8'h09);
        bus_act = 1; tick();
        check("R6 bus exit", {7'b0, susp_o}, 8'h00);

        // R7
        por();
        busrst_ev = 1; tick();
        check("R7 set", rd_data, 8'h31);
        wr(8'h51);
        check("R7 clear by write", rd_data, 8'h11);
        busrst_ev = 1; wr(8'h01);
        check("R7 set beats clear", rd_data, 8'h21);

        // R9
        por();
        irq_req = 1; tick();
        check("R9 set", rd_data, 8'h91);
        irq_src_en = 1; tick();
        check("R9 held, ie off", rd_data, 8'h81 | 8'h10);
        ei_ev = 1; tick();
        check("R9 held, src off", rd_data, 8'h95);
        irq_src_en = 1; tick();
        check("R9 taken", rd_data, 8'h15);

        // R11
        por();
        bus_addr = 8'hFE; wr_en = 1; wr_data = 8'h00; tick();
        bus_addr = 8'hFE;
        #1 check("R11 other addr reads 0", rd_data, 8'h00);
        bus_addr = 8'hFF;
        #1 check("R11 write elsewhere ignored", rd_data, 8'h11);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule